// File: doc/BRIEF.md
# Byte FIFO with Occupancy Readout and Fill Events

This block is a small byte queue for the two data paths of a serial controller. The transmit side holds outgoing bytes and the receive side holds incoming ones. A producer writes bytes on a push port and a consumer reads them on a pop port. Every status output is registered. These outputs are the full and empty flags, an occupancy value that a processor reads through its register decode, and a sticky error flag. The register decode and the serial engine sit outside this block.

The occupancy value is the number of stored bytes minus one. It carries meaning only while the empty flag is low. The threshold input uses the same minus-one encoding: the processor writes the fill level it wants minus one. A level-sensitive threshold event stays high while the fill is at or above that level. A synchronous flush input clears the contents, as the controller's FIFO reset bit does.

A parameter selects the transmit variant or the receive variant, and both use one core. The transmit variant adds two single-cycle events. One marks the queue draining to empty. The other marks it dropping to half of its depth, the point at which software can refill half the queue.

Top module: `byte_fifo`

## Requirements
- R1: After a cycle with `rst` high, `empty`=1, `full`=0, `err`=0, `occ_m1`=DEPTH-1 (all ones, 15 at the default depth), `pop_data`=0, and all three event outputs are 0.
- R2: Bytes leave in the order they were accepted. The byte for a successful pop appears on `pop_data` in the cycle after the pop, and `pop_data` holds that byte until the next successful pop.
- R3: In the cycle after each clock edge, `occ_m1` equals the stored count minus one, taken modulo DEPTH. `full` is 1 exactly when the count is DEPTH, and `empty` is 1 exactly when the count is 0.
- R4: A push while full, with no pop in the same cycle, is dropped. The queued bytes are unchanged and `err` is 1 from the next cycle.
- R5: A pop while empty leaves `pop_data` unchanged and sets `err` from the next cycle.
- R6: Once set, `err` stays 1 until `rst`. A flush does not clear it.
- R7: A cycle with `flush` high empties the queue, and `empty` is 1 in the next cycle. A push or pop in that same cycle has no effect, and no error is recorded for it.
- R8: A push and a pop in the same cycle while full both take effect. The popped byte is the oldest one, and the count stays at DEPTH.
- R9: `thr_evt` is 1 in the cycle after any edge at which the new count is at least `thr_m1`+1. It stays 1 for as long as that holds, in both variants.
- R10: In the transmit variant (`IS_TX`=1), `empty_evt` is a one-cycle pulse, following the edge at which the count goes from non-zero to zero, whether by pop or by flush.
- R11: In the transmit variant, `half_evt` is a one-cycle pulse, following the edge at which the count goes from DEPTH/2+1 to DEPTH/2.
- R12: In the receive variant (`IS_TX`=0), `empty_evt` and `half_evt` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of the stored bytes |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Byte to write |
| pop | input | 1 | Read request |
| pop_data | output | DATA_W | Last byte read, registered |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| occ_m1 | output | $clog2(DEPTH) | Stored count minus one |
| thr_m1 | input | $clog2(DEPTH) | Threshold fill level minus one |
| thr_evt | output | 1 | Fill is at or above the threshold |
| empty_evt | output | 1 | Transmit variant: drained to empty |
| half_evt | output | 1 | Transmit variant: dropped to half depth |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
The hardest situations to reach are those at a completely full queue. These are a push against a full queue, which must leave no trace in the data, and a combined push and pop while full, which must accept both. The stimulus fills the queue to its depth with numbered bytes, attempts an extra push and then a combined operation. It drains the whole queue and checks every byte in order, so a dropped or corrupted byte shows in the sequence. The same drain crosses the half-depth point and the empty point, so the transmit events are seen at their exact cycles. Both variants run side by side on identical stimulus.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int unsigned BYTE_W = 8;

  // Accepted operations for one cycle, shared between control and storage.
  typedef struct packed {
    logic do_push;
    logic do_pop;
  } bfifo_op_t;

  function automatic logic at_or_above(input int unsigned lvl_m1, input int unsigned cnt);
    return (cnt >= lvl_m1 + 1);
  endfunction
endpackage

// File: rtl/bfifo_mem.sv
module bfifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // Write port, no reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Registered read port; holds its value when no read happens.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import bfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output bfifo_op_t     op,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] occ_m1,
  output logic          err
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [CW-1:0] occ_d;
  logic          err_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    op.do_pop  = pop && !flush && (cnt_q != '0);
    op.do_push = push && !flush && ((cnt_q != FULL_CNT) || op.do_pop);
    if (flush) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(op.do_push) - CW'(op.do_pop);
    end
    occ_d = cnt_d - CW'(1);
    err_d = err | (!flush && ((push && !op.do_push) || (pop && !op.do_pop)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt_q  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
      occ_m1 <= '1;
      err    <= 1'b0;
    end else begin
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (op.do_push) wptr <= bump(wptr);
        if (op.do_pop)  rptr <= bump(rptr);
      end
      cnt_q  <= cnt_d;
      full   <= (cnt_d == FULL_CNT);
      empty  <= (cnt_d == '0);
      occ_m1 <= occ_d[AW-1:0];
      err    <= err_d;
    end
  end
endmodule

// File: rtl/bfifo_evt.sv
module bfifo_evt
  import bfifo_pkg::*;
#(
  parameter bit          IS_TX = 1'b1,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_d,
  input  logic [AW-1:0] thr_m1,
  output logic          thr_evt,
  output logic          empty_evt,
  output logic          half_evt
);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic drain_q;
  logic half_q;

  // Level event, present in both variants.
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_evt <= 1'b0;
    end else begin
      thr_evt <= at_or_above(int'(thr_m1), int'(cnt_d));
    end
  end

  // Edge events for the transmit side.
  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      drain_q <= (cnt_q != '0) && (cnt_d == '0);
      half_q  <= (cnt_q == HALF_CNT + CW'(1)) && (cnt_d == HALF_CNT);
    end
  end

  generate
    if (IS_TX) begin : g_tx
      assign empty_evt = drain_q;
      assign half_evt  = half_q;
    end else begin : g_rx
      assign empty_evt = drain_q & 1'b0;
      assign half_evt  = half_q & 1'b0;
    end
  endgenerate
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
  import bfifo_pkg::*;
#(
  parameter bit          IS_TX  = 1'b1,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = BYTE_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic [AW-1:0]     occ_m1,
  input  logic [AW-1:0]     thr_m1,
  output logic              thr_evt,
  output logic              empty_evt,
  output logic              half_evt,
  output logic              err
);
  bfifo_op_t     op;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  bfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .push   (push),
    .pop    (pop),
    .op     (op),
    .wptr   (wptr),
    .rptr   (rptr),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d),
    .full   (full),
    .empty  (empty),
    .occ_m1 (occ_m1),
    .err    (err)
  );

  bfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk   (clk),
    .rst   (rst),
    .we    (op.do_push),
    .waddr (wptr),
    .wdata (push_data),
    .re    (op.do_pop),
    .raddr (rptr),
    .rdata (pop_data)
  );

  bfifo_evt #(.IS_TX(IS_TX), .DEPTH(DEPTH), .AW(AW), .CW(CW)) evt_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d),
    .thr_m1    (thr_m1),
    .thr_evt   (thr_evt),
    .empty_evt (empty_evt),
    .half_evt  (half_evt)
  );
endmodule

// File: rtl/bfifo_chk.sv
module bfifo_chk #(
  parameter bit          IS_TX  = 1'b1,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] pop_data,
  input logic              full,
  input logic              empty,
  input logic [AW-1:0]     occ_m1,
  input logic              thr_evt,
  input logic              empty_evt,
  input logic              half_evt,
  input logic              err
);
  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst) !(full && empty));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> err);

  // R5
  underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> ($stable(pop_data) && err));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst) flush |=> empty);

  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && full && !flush) |=> full);

  // R9
  thr_nonempty_chk: assert property (@(posedge clk) disable iff (rst) thr_evt |-> !empty);

  generate
    if (IS_TX) begin : g_tx_chk
      // R10
      drain_evt_chk: assert property (@(posedge clk) disable iff (rst)
        empty_evt |-> (empty && !$past(empty)));
      // R11
      half_evt_chk: assert property (@(posedge clk) disable iff (rst)
        half_evt |-> (occ_m1 == AW'(DEPTH / 2 - 1)));
    end
  endgenerate
endmodule

bind byte_fifo bfifo_chk #(
  .IS_TX(IS_TX), .DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)
) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
  .pop_data(pop_data), .full(full), .empty(empty), .occ_m1(occ_m1),
  .thr_evt(thr_evt), .empty_evt(empty_evt), .half_evt(half_evt), .err(err)
);

// File: tb/byte_fifo_tb_top.sv
`timescale 1ns/1ps
module byte_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic push = 1'b0;
  logic pop = 1'b0;
  logic [7:0] push_data = '0;
  logic [AW-1:0] thr_m1 = '0;

  logic [7:0] tx_pd, rx_pd;
  logic tx_full, rx_full, tx_empty, rx_empty, tx_thr, rx_thr;
  logic tx_eev, rx_eev, tx_hev, rx_hev, tx_err, rx_err;
  logic [AW-1:0] tx_occ, rx_occ;

  always #(CLK_HALF) clk = ~clk;

  byte_fifo #(.IS_TX(1'b1), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(tx_pd), .full(tx_full), .empty(tx_empty),
    .occ_m1(tx_occ), .thr_m1(thr_m1), .thr_evt(tx_thr),
    .empty_evt(tx_eev), .half_evt(tx_hev), .err(tx_err));

  byte_fifo #(.IS_TX(1'b0), .DEPTH(DEPTH)) dut_rx_i (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(rx_pd), .full(rx_full), .empty(rx_empty),
    .occ_m1(rx_occ), .thr_m1(thr_m1), .thr_evt(rx_thr),
    .empty_evt(rx_eev), .half_evt(rx_hev), .err(rx_err));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] model[$];
  logic [7:0] sb_q[$];
  bit         sb_under[$];
  logic [7:0] m_last = '0;
  bit         m_err = 0;
  bit         mon_go = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares popped data against the scoreboard.
  always @(negedge clk) begin
    if (mon_go) begin
      logic [7:0] e;
      bit u;
      mon_go = 0;
      e = sb_q.pop_front();
      u = sb_under.pop_front();
      chk(u ? "R5 pop_data held (tx)" : "R2 order (tx)", int'(tx_pd), int'(e));
      chk(u ? "R5 pop_data held (rx)" : "R2 order (rx)", int'(rx_pd), int'(e));
    end
  end

  task automatic model_reset();
    model.delete();
    m_last = '0;
    m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    // R1
    chk("R1 empty", int'(tx_empty), 1);
    chk("R1 full", int'(tx_full), 0);
    chk("R1 err", int'(tx_err), 0);
    chk("R1 occ_m1", int'(tx_occ), DEPTH - 1);
    chk("R1 pop_data", int'(tx_pd), 0);
    chk("R1 events", int'({tx_eev, tx_hev, tx_thr, rx_thr}), 0);
  endtask

  task automatic step(input bit p, input logic [7:0] d, input bit q, input bit f);
    int old_n, new_n;
    bit dpop, dpush, under;
    @(negedge clk);
    push = p; push_data = d; pop = q; flush = f;
    old_n = model.size();
    dpop = 0; under = 0;
    if (f) begin
      model.delete();
    end else begin
      dpop  = q && (old_n != 0);
      dpush = p && ((old_n < DEPTH) || dpop);
      if (q && !dpop) begin
        m_err = 1;
        under = 1;
      end
      if (p && !dpush) m_err = 1;
      if (dpop) m_last = model.pop_front();
      if (dpush) model.push_back(d);
    end
    new_n = model.size();
    if (dpop || under) begin
      sb_q.push_back(m_last);
      sb_under.push_back(under);
    end
    @(posedge clk);
    #1;
    push = 0; pop = 0; flush = 0;
    mon_go = dpop || under;
    chk("R3 empty", int'(tx_empty), int'(new_n == 0));
    chk("R3 full", int'(tx_full), int'(new_n == DEPTH));
    chk("R3 occ_m1 tx", int'(tx_occ), (new_n - 1) & (DEPTH - 1));
    chk("R3 occ_m1 rx", int'(rx_occ), (new_n - 1) & (DEPTH - 1));
    chk("R6 err", int'(tx_err), int'(m_err));
    chk("R9 thr tx", int'(tx_thr), int'(new_n >= int'(thr_m1) + 1));
    chk("R9 thr rx", int'(rx_thr), int'(new_n >= int'(thr_m1) + 1));
    chk("R10 empty_evt", int'(tx_eev), int'(old_n != 0 && new_n == 0));
    chk("R11 half_evt", int'(tx_hev), int'(old_n == DEPTH / 2 + 1 && new_n == DEPTH / 2));
    chk("R12 rx events", int'({rx_eev, rx_hev}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    thr_m1 = 4'd3;
    for (int i = 0; i < 5; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    // R5: pop on empty
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R5 err set", int'(rx_err), 1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    // R7: flush with content, push and pop in the same cycle
    for (int i = 0; i < 3; i++) step(1'b1, 8'h20 + 8'(i), 1'b0, 1'b0);
    step(1'b1, 8'hAA, 1'b1, 1'b1);
    chk("R7 empty after flush", int'(rx_empty), 1);
    chk("R7 err kept", int'(tx_err), 1);
    step(1'b1, 8'h30, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    // R6: reset clears err
    do_reset();
    thr_m1 = 4'd15;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0);
    // R4: overflow
    step(1'b1, 8'hEE, 1'b0, 1'b0);
    chk("R4 err", int'(tx_err), 1);
    chk("R4 still full", int'(tx_full), 1);
    // R8: simultaneous push and pop while full
    step(1'b1, 8'h77, 1'b1, 1'b0);
    chk("R8 full kept", int'(tx_full), 1);
    thr_m1 = 4'd7;
    for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule